// File: doc/BRIEF.md
# Peak-Current Terminated PWM Generator

This block produces one PWM drive signal from a free-running up-counter. Every switching period opens with the drive high. The drive falls at the first of two events. One is a trip from an external peak-current comparator, which means the inductor current has reached its reference. The other is the counter reaching the effective duty count, which is the backstop on on-time. Once the drive has fallen it stays low until the next period opens.

The comparator trip arrives asynchronously and passes through a two-stage synchronizer. The trip is then masked for a programmable number of clocks after the drive rises, so that switching spikes at turn-on cannot end the pulse. The period, duty, maximum-duty and blanking settings are held in shadow registers and copied into the working set only when a period opens.

The block marks the first clock of each period with a strobe. A flag records whether the latest pulse ended through a current trip or through the duty count. Firmware writes the settings, and a peak-current reference set elsewhere drives the comparator.

Top module: `cmt_pwm`

## Requirements
- R1: With period setting P, each period lasts P+1 clocks, indexed 0..P. `start_o` is high during index 0 only.
- R2: When no trip is accepted, `pwm_o` is high during indices 0..E-1 and low for the rest of the period. E is the effective duty.
- R3: The effective duty E is the smaller of the duty setting and the maximum-duty setting, so the maximum duty caps on-time whatever the duty setting is.
- R4: When E is 0, `pwm_o` stays low for the whole period and `trip_end_o` reads 0 from index 0.
- R5: A trip level on `trip_async` that is first sampled high at a rising edge is accepted two edges later. If the trip is accepted at index k, `pwm_o` is low from index k+1 onward.
- R6: A trip seen at an index below the blanking setting B is ignored. The first index at which a trip can be accepted is B.
- R7: After the pulse ends, `pwm_o` stays low for the rest of the period, even while the trip input keeps changing.
- R8: `trip_end_o` becomes 1 when a pulse ends by an accepted trip and becomes 0 when a pulse ends by the duty count. If both happen at the same index, the trip wins. The new value is visible from the clock after the pulse ends.
- R9: The period, duty, maximum-duty and blanking inputs take effect only at the next period start. Changes made during a period do not alter that period.
- R10: While `en` is low, `pwm_o` and `start_o` are 0 from the next clock. At the first rising edge with `en` high, a new period opens and `start_o` is high in the clock after that edge.
- R11: During reset, `pwm_o`, `start_o` and `trip_end_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable. Low holds the block idle with the drive off |
| period_in | input | CW | Period setting P. The period lasts P+1 clocks |
| duty_in | input | CW | Programmed duty, in clocks |
| max_duty_in | input | CW | Maximum on-time, in clocks |
| blank_in | input | BW | Leading-edge blanking length, in clocks |
| trip_async | input | 1 | Asynchronous peak-current comparator trip |
| pwm_o | output | 1 | PWM drive |
| start_o | output | 1 | High during the first clock of each period |
| trip_end_o | output | 1 | 1 if the latest pulse ended by a trip, 0 if it ended by the duty count |

## Verification
The assertions take for granted that `en` changes only between clock edges. They also assume the effective duty fits the period being run. When E is above P, the pulse never ends by duty count; that case only extends the drive into the next period, and the checks on when the drive may fall do not cover it. The bench keeps every sweep vector with both duty and maximum duty at or below P. It drives the trip input at the falling edge, so the synchronizer sees clean levels. It also releases the trip two indices before the period ends, so no trip spills into the index 0 of the next period.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic {
    END_BY_DUTY = 1'b0,
    END_BY_TRIP = 1'b1
  } end_cause_e;

  // on-time allowed for a period: programmed duty capped by the limit
  function automatic int unsigned eff_duty(input int unsigned duty, input int unsigned limit);
    return (duty < limit) ? duty : limit;
  endfunction

  // true once the blanking window after the rising edge has elapsed
  function automatic logic blank_over(input int unsigned idx, input int unsigned blank);
    return idx >= blank;
  endfunction

  // true when the next index would reach the on-time count
  function automatic logic duty_reached(input int unsigned idx, input int unsigned eff);
    return (idx + 1) == eff;
  endfunction

endpackage

// File: rtl/cmt_sync.sv
module cmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmt_shadow.sv
module cmt_shadow #(
  parameter int CW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] max_duty_in,
  input  logic [BW-1:0] blank_in,
  output logic [CW-1:0] eff_next,
  output logic [CW-1:0] per_a,
  output logic [CW-1:0] eff_a,
  output logic [BW-1:0] blank_a
);
  assign eff_next = CW'(cmt_pkg::eff_duty(int'(duty_in), int'(max_duty_in)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a   <= '0;
      eff_a   <= '0;
      blank_a <= '0;
    end else if (load) begin
      per_a   <= period_in;
      eff_a   <= eff_next;
      blank_a <= blank_in;
    end
  end
endmodule

// File: rtl/cmt_timebase.sv
module cmt_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] per_a,
  output logic [CW-1:0] cnt,
  output logic          load,
  output logic          start_o
);
  logic running;
  logic wrap;

  assign wrap = (cnt == per_a);
  assign load = en && (!running || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      start_o <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      running <= 1'b0;
      start_o <= 1'b0;
    end else begin
      running <= 1'b1;
      start_o <= load;
      cnt     <= load ? '0 : cnt + 1'b1;
    end
  end

  assert_start_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (cnt == '0));
  assert_wrap_at_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(running)) |-> ($past(cnt) == $past(per_a)));
endmodule

// File: rtl/cmt_pwm.sv
module cmt_pwm #(
  parameter int CW         = 8,
  parameter int BW         = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] max_duty_in,
  input  logic [BW-1:0] blank_in,
  input  logic          trip_async,
  output logic          pwm_o,
  output logic          start_o,
  output logic          trip_end_o
);
  import cmt_pkg::*;

  logic [CW-1:0] cnt, per_a, eff_a, eff_next;
  logic [BW-1:0] blank_a;
  logic          load;
  logic          trip_s;
  logic          pwm_q;
  end_cause_e    cause_q;

  // named events for the checks below
  logic unblanked, trip_hit, duty_hit;

  cmt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trip_async), .q(trip_s)
  );

  cmt_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .per_a(per_a),
    .cnt(cnt), .load(load), .start_o(start_o)
  );

  cmt_shadow #(.CW(CW), .BW(BW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .period_in(period_in), .duty_in(duty_in), .max_duty_in(max_duty_in),
    .blank_in(blank_in), .eff_next(eff_next),
    .per_a(per_a), .eff_a(eff_a), .blank_a(blank_a)
  );

  assign unblanked = blank_over(int'(cnt), int'(blank_a));
  assign trip_hit  = pwm_q && trip_s && unblanked;
  assign duty_hit  = pwm_q && duty_reached(int'(cnt), int'(eff_a));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      cause_q <= END_BY_DUTY;
    end else if (!en) begin
      pwm_q   <= 1'b0;
    end else begin
      if (trip_hit)      cause_q <= END_BY_TRIP;
      else if (duty_hit) cause_q <= END_BY_DUTY;
      if (load) begin
        pwm_q <= (eff_next != '0);
        if (eff_next == '0) cause_q <= END_BY_DUTY;
      end else if (trip_hit || duty_hit) begin
        pwm_q <= 1'b0;
      end
    end
  end

  assign pwm_o      = pwm_q;
  assign trip_end_o = (cause_q == END_BY_TRIP);

  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> start_o);
  assert_width_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_o |-> (int'(cnt) < int'(eff_a)));
  assert_blank_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_o) && $past(en) && !start_o && (int'($past(cnt)) < int'($past(blank_a))))
      |-> (int'($past(cnt)) + 1 == int'($past(eff_a))));
  assert_cause_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_end_o) |-> ($fell(pwm_o) || start_o));
  assert_idle_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_o && !start_o));
endmodule

// File: tb/tb_cmt_pwm.sv
module tb_cmt_pwm;
  localparam int CW = 8;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] period_in = '0, duty_in = '0, max_duty_in = '0;
  logic [BW-1:0] blank_in = '0;
  logic trip_async = 1'b0;
  logic pwm_o, start_o, trip_end_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cmt_pwm #(.CW(CW), .BW(BW), .SYNC_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_in(period_in), .duty_in(duty_in), .max_duty_in(max_duty_in),
    .blank_in(blank_in), .trip_async(trip_async),
    .pwm_o(pwm_o), .start_o(start_o), .trip_end_o(trip_end_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!start_o);
  endtask

  // one measured period; trip seen (after sync) from index t onward
  task automatic run_vec(input int p, input int d, input int m, input int b, input int t);
    int eff, kv, len, shape_bad, start_bad, exp_cause;
    bit has_kv;
    eff = (d < m) ? d : m;
    kv  = (t > b) ? t : b;
    has_kv = (t <= p) && (kv <= p);
    len = (eff == 0) ? 0 : ((has_kv && kv < eff) ? kv + 1 : eff);
    exp_cause = (eff != 0 && has_kv && kv < eff) ? 1 : 0;
    shape_bad = 0;
    start_bad = 0;
    @(negedge clk);
    period_in = CW'(p); duty_in = CW'(d); max_duty_in = CW'(m); blank_in = BW'(b);
    trip_async = 1'b0;
    wait_start();
    // R9: settings changed mid-period must not touch this period
    period_in = CW'(3); duty_in = CW'(3); max_duty_in = CW'(3); blank_in = '0;
    for (int k = 0; k <= p; k++) begin
      if (pwm_o !== ((k < len) ? 1'b1 : 1'b0)) shape_bad++;
      if (start_o !== ((k == 0) ? 1'b1 : 1'b0)) start_bad++;
      trip_async = (t <= p) && (k + 2 >= t) && (k <= p - 2);
      if (k == p) begin
        check(trip_end_o === exp_cause[0], "R8 cause flag", int'(trip_end_o), exp_cause);
      end else begin
        @(negedge clk);
      end
    end
    trip_async = 1'b0;
    check(shape_bad == 0, (eff == 0) ? "R4 zero duty" :
          (exp_cause != 0) ? "R5/R6/R7 trip cut" : "R2/R3 duty end",
          shape_bad, 0);
    check(start_bad == 0, "R1 period strobe", start_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    en = 1'b1;
    trip_async = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(pwm_o === 1'b0 && start_o === 1'b0 && trip_end_o === 1'b0,
            "R11 reset outputs", {pwm_o, start_o, trip_end_o}, 0);
    end
    trip_async = 1'b0;
    period_in = 8'd4; duty_in = 8'd2; max_duty_in = 8'd4; blank_in = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check(start_o === 1'b1 && pwm_o === 1'b1, "R10 first period", {start_o, pwm_o}, 3);

    // sweep over small periods
    for (int p = 3; p <= 6; p++)
      for (int d = 0; d <= p; d++)
        for (int mi = 0; mi < 3; mi++)
          for (int b = 0; b <= 3; b++)
            for (int ti = 0; ti < 4; ti++) begin
              int m, t;
              m = (mi == 0) ? 0 : (mi == 1) ? 2 : p;
              t = (ti == 3) ? p + 2 : ti + 2;
              run_vec(p, d, m, b, t);
            end

    // R10: drop enable mid-pulse, then resume
    @(negedge clk);
    period_in = 8'd6; duty_in = 8'd6; max_duty_in = 8'd6; blank_in = '0;
    wait_start();
    wait_start();
    en = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(pwm_o === 1'b0 && start_o === 1'b0, "R10 disabled idle", {pwm_o, start_o}, 0);
    end
    en = 1'b1;
    @(negedge clk);
    check(start_o === 1'b1 && pwm_o === 1'b1, "R10 restart", {start_o, pwm_o}, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule